// File: doc/BRIEF.md
# Multi-mode 16-bit timer core

This block is a 16-bit counter for timing and periodic interrupts. Software configures it through three word registers: control, counter and interrupt vector. The control register holds the counting mode, the tick source, the tick divider, a self-clearing clear bit, and a wrap flag with its enable. Four synchronous tick-enable strobes arrive from the clock domain logic. One of them is selected and divided by 1, 2, 4 or 8. Each divided tick advances the counter once.

The counter can hold, count up to a period, count freely across the full 16-bit range, or count up to the period and back down to zero. The period comes from compare channel 0, which lies outside this block, on the `period_i` port. Two further compare channels report their pending requests on `ch_pend_i`. The vector register names the most urgent of these requests and the wrap flag. Reading the vector acknowledges the source it named.

Register map on `addr_i`: 0 = control, 1 = counter (read and write), 2 = vector. Register 3 reads 0.

Top module: `tick_timer_core`

## Requirements
- R1: After reset the counter, the control register, the vector and `irq_o` are all 0.
- R2: Mode field value 00 (stop) holds the counter at its value while ticks arrive.
- R3: Mode 01 (up) counts from 0 to `period_i` inclusive, so one period is `period_i`+1 divided ticks. The flag sets each time the counter returns to 0. If the period is lowered below the current count, the counter goes to 0 on its next tick.
- R4: In mode 01 a `period_i` of 0 stops counting. A non-zero period resumes counting from the held value.
- R5: Mode 10 (continuous) counts through 0xFFFF and wraps to 0. That wrap sets the flag. A write to register 1 loads the counter.
- R6: Mode 11 (up/down) counts up to `period_i` and then down to 0. One period is 2×`period_i` ticks. The flag sets when the count reaches 0 going down.
- R7: Divider field (control bits 7:6) values 00, 01, 10 and 11 advance the counter once every 1, 2, 4 and 8 selected ticks. Counting starts from a cleared divider.
- R8: Source field (control bits 9:8) value k selects `tick_src_i[k]`. Strobes on the other inputs have no effect.
- R9: Writing 1 to control bit 2 clears the counter, the divider state and the count direction, all in one cycle. Bit 2 always reads 0.
- R10: Control layout: bit 0 is the flag (writable), bit 1 is the interrupt enable, bits 5:4 are the mode, bits 7:6 the divider and bits 9:8 the source. Bits 3:2 and 15:10 read 0.
- R11: The vector register reads 0x02 when channel 1 (`ch_pend_i[0]`) is pending, 0x04 when channel 2 (`ch_pend_i[1]`) is pending, 0x0A when the flag is set, and 0x00 when nothing is pending. The priority order is channel 1, then channel 2, then the flag.
- R12: A read of the vector (`rd_en_i` at address 2) clears the flag only when it reported 0x0A. For a channel code it pulses the matching `ch_ack_o` bit instead.
- R13: `irq_o` is high when the flag and its enable are both set, or when either channel is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effects on the vector) |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational from `addr_i` |
| tick_src_i | input | 4 | Tick-enable strobes, one per source |
| period_i | input | 16 | Period from compare channel 0 |
| ch_pend_i | input | 2 | Pending requests of channels 1 and 2 |
| ch_ack_o | output | 2 | Acknowledge pulse for channels 1 and 2 |
| irq_o | output | 1 | Interrupt request |
| count_o | output | 16 | Current count |

## Verification
The checker watches some properties on every cycle:
- The count does not move in stop mode.
- Continuous mode steps by at most one.
- In up and up/down modes the count stays at or below the period it was compared against.
- A clear always leaves a zero count.
- Channel 1 has priority in the vector.
- Channel requests always raise the interrupt.
- At most one acknowledge bit is active at a time.
- The reserved control bits read 0.

Other behaviours can only be shown by the bench's scenarios:
- exact count sequences over many periods and dividers;
- where the flag sets;
- that unselected sources are ignored;
- that a clear resets the direction and the divider;
- that a vector read clears the flag.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_STOP = 2'b00,
    MODE_UP   = 2'b01,
    MODE_CONT = 2'b10,
    MODE_UPDN = 2'b11
  } tmr_mode_e;

  localparam int N_SRC = 4;
  localparam int SEL_W = 2;
  localparam int DSEL_W = 2;
  localparam int N_CH = 2;
  localparam int CODE_W = 4;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CNT  = 2'd1;
  localparam logic [1:0] ADDR_VEC  = 2'd2;

  localparam int BIT_FLAG = 0;
  localparam int BIT_IE   = 1;
  localparam int BIT_CLR  = 2;
  localparam int LSB_MODE = 4;
  localparam int LSB_DIV  = 6;
  localparam int LSB_SRC  = 8;

  localparam logic [CODE_W-1:0] VEC_NONE = 4'h0;
  localparam logic [CODE_W-1:0] VEC_OVF  = 4'hA;
endpackage

// File: rtl/tmr_tick_div.sv
`timescale 1ns/1ps
module tmr_tick_div
  import tmr_pkg::*;
#(
  parameter int DIV_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  tick_src_i,
  input  logic [SEL_W-1:0]  src_sel_i,
  input  logic [DSEL_W-1:0] div_sel_i,
  input  logic              run_i,
  input  logic              clr_i,
  output logic              adv_o
);
  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] pre_mask;
  logic             sel_tick;
  logic             step;

  // low div_sel bits of the prescaler must all be set to pass a tick
  for (genvar g = 0; g < DIV_W; g++) begin : g_mask
    assign pre_mask[g] = (int'(div_sel_i) > g);
  end

  assign sel_tick = tick_src_i[src_sel_i];
  assign step     = run_i & sel_tick;
  assign adv_o    = step & ((pre_q & pre_mask) == pre_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pre_q <= '0;
    else if (clr_i) pre_q <= '0;
    else if (step)  pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/tmr_count_unit.sv
`timescale 1ns/1ps
module tmr_count_unit
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             clr_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  tmr_mode_e        mode_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             down_q, down_d;
  logic             wrap;

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    wrap   = 1'b0;
    if (adv_i) begin
      unique case (mode_i)
        MODE_UP: begin
          // also catches a period lowered below the count
          if (cnt_q >= period_i) begin
            cnt_d = '0;
            wrap  = 1'b1;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        MODE_CONT: begin
          cnt_d = cnt_q + ONE;
          wrap  = (cnt_q == CNT_MAX);
        end
        MODE_UPDN: begin
          if (!down_q) begin
            if (cnt_q < period_i) begin
              cnt_d = cnt_q + ONE;
            end else if (cnt_q == ONE) begin
              cnt_d = '0;
              wrap  = 1'b1;
            end else begin
              cnt_d  = cnt_q - ONE;
              down_d = 1'b1;
            end
          end else begin
            if (cnt_q == ONE) begin
              cnt_d  = '0;
              down_d = 1'b0;
              wrap   = 1'b1;
            end else if (cnt_q == '0) begin
              cnt_d  = ONE;
              down_d = 1'b0;
            end else begin
              cnt_d = cnt_q - ONE;
            end
          end
        end
        default: ;
      endcase
    end
    if (ld_i) begin
      cnt_d = ld_val_i;
      wrap  = 1'b0;
    end
    if (clr_i) begin
      cnt_d  = '0;
      down_d = 1'b0;
      wrap   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap;
endmodule

// File: rtl/tmr_irq_vec.sv
`timescale 1ns/1ps
module tmr_irq_vec
  import tmr_pkg::*;
(
  input  logic [N_CH-1:0]   ch_pend_i,
  input  logic              ovf_i,
  input  logic              ie_i,
  input  logic              rd_i,
  output logic [CODE_W-1:0] code_o,
  output logic [N_CH-1:0]   ack_o,
  output logic              ovf_clr_o,
  output logic              irq_o
);
  logic [N_CH-1:0] hit;
  logic            ovf_sel;

  // lowest channel index wins; flag only when no channel pends
  always_comb begin
    code_o  = VEC_NONE;
    hit     = '0;
    ovf_sel = 1'b0;
    if (ovf_i) begin
      code_o  = VEC_OVF;
      ovf_sel = 1'b1;
    end
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (ch_pend_i[i]) begin
        code_o  = CODE_W'(2 * (i + 1));
        hit     = '0;
        hit[i]  = 1'b1;
        ovf_sel = 1'b0;
      end
    end
  end

  assign ack_o     = rd_i ? hit : '0;
  assign ovf_clr_o = rd_i & ovf_sel;
  assign irq_o     = (ovf_i & ie_i) | (|ch_pend_i);
endmodule

// File: rtl/tick_timer_core.sv
`timescale 1ns/1ps
module tick_timer_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic [3:0]       tick_src_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [1:0]       ch_pend_i,
  output logic [1:0]       ch_ack_o,
  output logic             irq_o,
  output logic [CNT_W-1:0] count_o
);
  tmr_mode_e         mode_q;
  logic [DSEL_W-1:0] div_q;
  logic [SEL_W-1:0]  src_q;
  logic              ovf_q, ie_q;

  logic ctrl_wr, cnt_wr, vec_rd, clr;
  logic run, adv, wrap, ovf_clr;
  logic [CNT_W-1:0]  cnt;
  logic [CODE_W-1:0] vec_code;
  logic [CNT_W-1:0]  ctrl_rd;

  assign ctrl_wr = wr_en_i && (addr_i == ADDR_CTRL);
  assign cnt_wr  = wr_en_i && (addr_i == ADDR_CNT);
  assign vec_rd  = rd_en_i && (addr_i == ADDR_VEC);
  assign clr     = ctrl_wr && wdata_i[BIT_CLR];

  // up and up/down (mode bit 0 set) halt on a zero period
  assign run = (mode_q != MODE_STOP) && !(mode_q[0] && (period_i == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_STOP;
      div_q  <= '0;
      src_q  <= '0;
      ie_q   <= 1'b0;
    end else if (ctrl_wr) begin
      mode_q <= tmr_mode_e'(wdata_i[LSB_MODE +: 2]);
      div_q  <= wdata_i[LSB_DIV +: DSEL_W];
      src_q  <= wdata_i[LSB_SRC +: SEL_W];
      ie_q   <= wdata_i[BIT_IE];
    end
  end

  // hardware set wins over software write and vector-read clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ovf_q <= 1'b0;
    else if (wrap)    ovf_q <= 1'b1;
    else if (ctrl_wr) ovf_q <= wdata_i[BIT_FLAG];
    else if (ovf_clr) ovf_q <= 1'b0;
  end

  tmr_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_src_i (tick_src_i),
    .src_sel_i  (src_q),
    .div_sel_i  (div_q),
    .run_i      (run),
    .clr_i      (clr),
    .adv_o      (adv)
  );

  tmr_count_unit #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (adv),
    .clr_i    (clr),
    .ld_i     (cnt_wr),
    .ld_val_i (wdata_i),
    .mode_i   (mode_q),
    .period_i (period_i),
    .cnt_o    (cnt),
    .wrap_o   (wrap)
  );

  tmr_irq_vec u_vec (
    .ch_pend_i (ch_pend_i),
    .ovf_i     (ovf_q),
    .ie_i      (ie_q),
    .rd_i      (vec_rd),
    .code_o    (vec_code),
    .ack_o     (ch_ack_o),
    .ovf_clr_o (ovf_clr),
    .irq_o     (irq_o)
  );

  always_comb begin
    ctrl_rd                     = '0;
    ctrl_rd[BIT_FLAG]           = ovf_q;
    ctrl_rd[BIT_IE]             = ie_q;
    ctrl_rd[LSB_MODE +: 2]      = mode_q;
    ctrl_rd[LSB_DIV +: DSEL_W]  = div_q;
    ctrl_rd[LSB_SRC +: SEL_W]   = src_q;
  end

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: rdata_o = ctrl_rd;
      ADDR_CNT:  rdata_o = cnt;
      ADDR_VEC:  rdata_o = CNT_W'(vec_code);
      default:   rdata_o = '0;
    endcase
  end

  assign count_o = cnt;
endmodule

// File: rtl/tick_timer_core_chk.sv
`timescale 1ns/1ps
module tick_timer_core_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       addr_i,
  input logic [CNT_W-1:0] wdata_i,
  input logic [CNT_W-1:0] rdata_o,
  input logic [CNT_W-1:0] period_i,
  input logic [1:0]       ch_pend_i,
  input logic [1:0]       ch_ack_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] count_o,
  input logic [1:0]       mode_i
);
  assert_stop_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00 && !wr_en_i) |=> (count_o == $past(count_o)));

  assert_up_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && !wr_en_i && count_o <= period_i) |=> (count_o <= $past(period_i)));

  assert_cont_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && !wr_en_i) |=>
      (count_o == $past(count_o) || count_o == CNT_W'($past(count_o) + 1'b1)));

  assert_updn_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && !wr_en_i && count_o <= period_i) |=> (count_o <= $past(period_i)));

  assert_clear_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_CTRL && wdata_i[BIT_CLR]) |=> (count_o == '0));

  assert_ctrl_rsvd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_CTRL) |-> (rdata_o[CNT_W-1:10] == '0 && rdata_o[3:2] == 2'b00));

  assert_vec_prio_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_VEC && ch_pend_i[0]) |-> (rdata_o == CNT_W'(2)));

  assert_ack_onehot_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_ack_o));

  assert_irq_chan_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ch_pend_i) |-> irq_o);
endmodule

bind tick_timer_core tick_timer_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .period_i  (period_i),
  .ch_pend_i (ch_pend_i),
  .ch_ack_o  (ch_ack_o),
  .irq_o     (irq_o),
  .count_o   (count_o),
  .mode_i    (mode_q)
);

// File: tb/tick_timer_core_tb_top.sv
`timescale 1ns/1ps
module tick_timer_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  tick = '0;
  logic [15:0] period = '0;
  logic [1:0]  ch = '0;
  logic [1:0]  ack;
  logic        irq;
  logic [15:0] count;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  tick_timer_core dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .rd_en_i    (rd_en),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .tick_src_i (tick),
    .period_i   (period),
    .ch_pend_i  (ch),
    .ch_ack_o   (ack),
    .irq_o      (irq),
    .count_o    (count)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0h exp %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cw(input int src, input int dv, input int md,
                                     input bit cl, input bit ie, input bit fl);
    cw = 16'((src << 8) | (dv << 6) | (md << 4) | (int'(cl) << 2) | (int'(ie) << 1) | int'(fl));
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      tick[idx] = 1'b1;
      @(negedge clk);
    end
    tick = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic rd_vec(output logic [15:0] v, output logic [1:0] a);
    @(negedge clk);
    rd_en = 1'b1; addr = 2'd2;
    #1;
    v = rdata; a = ack;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog: got 0 exp 1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [1:0]  a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 16'h0);
    rd(2'd1, v); chk("R1 count", v, 16'h0);
    rd(2'd2, v); chk("R1 vector", v, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);

    // R2 stop mode holds
    wr(2'd1, 16'h0033);
    run(0, 9);
    rd(2'd1, v); chk("R2 stop hold", v, 16'h0033);

    // R3 up mode sweep
    for (int p = 1; p <= 6; p++) begin
      for (int n = 0; n <= 3 * p + 1; n++) begin
        period = 16'(p);
        wr(2'd0, cw(0, 0, 1, 1, 0, 0));
        run(0, n);
        rd(2'd1, v); chk("R3 up count", v, 16'(n % (p + 1)));
        rd(2'd0, v); chk("R3 up flag", {15'b0, v[0]}, 16'(n >= p + 1));
      end
    end

    // R3 period lowered below count
    period = 16'd10;
    wr(2'd0, cw(0, 0, 1, 1, 0, 0));
    run(0, 7);
    rd(2'd1, v); chk("R3 before lower", v, 16'd7);
    period = 16'd3;
    run(0, 1);
    rd(2'd1, v); chk("R3 lowered to zero", v, 16'd0);
    rd(2'd0, v); chk("R3 lowered flag", {15'b0, v[0]}, 16'd1);

    // R4 zero period halts, non-zero resumes
    period = 16'd0;
    wr(2'd0, cw(0, 0, 1, 1, 0, 0));
    run(0, 5);
    rd(2'd1, v); chk("R4 zero period", v, 16'd0);
    period = 16'd5;
    run(0, 3);
    rd(2'd1, v); chk("R4 resume", v, 16'd3);

    // R5 continuous wrap
    wr(2'd0, cw(0, 0, 2, 1, 0, 0));
    wr(2'd1, 16'hFFFC);
    run(0, 3);
    rd(2'd1, v); chk("R5 at max", v, 16'hFFFF);
    rd(2'd0, v); chk("R5 no flag yet", {15'b0, v[0]}, 16'd0);
    run(0, 1);
    rd(2'd1, v); chk("R5 wrapped", v, 16'h0000);
    rd(2'd0, v); chk("R5 flag", {15'b0, v[0]}, 16'd1);
    run(0, 2);
    rd(2'd1, v); chk("R5 after wrap", v, 16'd2);

    // R6 up/down sweep
    for (int p = 1; p <= 5; p++) begin
      for (int n = 0; n <= 4 * p + 1; n++) begin
        int m;
        m = n % (2 * p);
        period = 16'(p);
        wr(2'd0, cw(0, 0, 3, 1, 0, 0));
        run(0, n);
        rd(2'd1, v); chk("R6 updn count", v, 16'((m <= p) ? m : 2 * p - m));
        rd(2'd0, v); chk("R6 updn flag", {15'b0, v[0]}, 16'(n >= 2 * p));
      end
    end

    // R7 divider sweep
    period = 16'd200;
    for (int d = 0; d < 4; d++) begin
      for (int n = 0; n <= 20; n++) begin
        wr(2'd0, cw(0, d, 1, 1, 0, 0));
        run(0, n);
        rd(2'd1, v); chk("R7 divide", v, 16'(n >> d));
      end
    end

    // R8 source selection
    for (int s = 0; s < 4; s++) begin
      wr(2'd0, cw(s, 0, 1, 1, 0, 0));
      for (int o = 0; o < 4; o++) if (o != s) run(o, 5);
      rd(2'd1, v); chk("R8 unselected ignored", v, 16'd0);
      run(s, 3);
      rd(2'd1, v); chk("R8 selected", v, 16'd3);
    end

    // R9 clear resets direction
    period = 16'd4;
    wr(2'd0, cw(0, 0, 3, 1, 0, 0));
    run(0, 5);
    rd(2'd1, v); chk("R9 going down", v, 16'd3);
    wr(2'd0, cw(0, 0, 3, 1, 0, 0));
    rd(2'd1, v); chk("R9 cleared", v, 16'd0);
    rd(2'd0, v); chk("R9 clear reads 0", {15'b0, v[2]}, 16'd0);
    wr(2'd1, 16'd2);
    run(0, 1);
    rd(2'd1, v); chk("R9 direction up", v, 16'd3);
    // R9 clear resets divider
    period = 16'd100;
    wr(2'd0, cw(0, 2, 1, 1, 0, 0));
    run(0, 3);
    wr(2'd0, cw(0, 2, 1, 1, 0, 0));
    run(0, 1);
    rd(2'd1, v); chk("R9 divider reset", v, 16'd0);
    run(0, 3);
    rd(2'd1, v); chk("R9 divider restart", v, 16'd1);

    // R10 layout and reserved bits
    period = 16'd0;
    wr(2'd0, 16'hFFFF);
    rd(2'd0, v); chk("R10 readback", v, 16'h03F3);
    wr(2'd0, cw(2, 1, 2, 0, 1, 0));
    rd(2'd0, v); chk("R10 fields", v, 16'h0262);

    // R11 / R12 / R13 vector and interrupt
    wr(2'd0, cw(0, 0, 0, 1, 1, 1));
    chk("R13 flag and enable", {15'b0, irq}, 16'd1);
    ch = 2'b01;
    rd_vec(v, a);
    chk("R11 channel 1", v, 16'h0002);
    chk("R12 ack channel 1", {14'b0, a}, 16'h0001);
    rd(2'd0, v); chk("R12 flag kept", {15'b0, v[0]}, 16'd1);
    ch = 2'b10;
    rd(2'd2, v); chk("R11 channel 2", v, 16'h0004);
    ch = 2'b11;
    rd(2'd2, v); chk("R11 priority", v, 16'h0002);
    ch = 2'b00;
    rd_vec(v, a);
    chk("R11 overflow", v, 16'h000A);
    chk("R12 no ack", {14'b0, a}, 16'h0000);
    rd(2'd0, v); chk("R12 flag cleared", {15'b0, v[0]}, 16'd0);
    rd(2'd2, v); chk("R11 none", v, 16'h0000);
    chk("R13 idle", {15'b0, irq}, 16'd0);
    ch = 2'b10; #1;
    chk("R13 channel", {15'b0, irq}, 16'd1);
    ch = 2'b00;
    wr(2'd0, cw(0, 0, 0, 0, 0, 1));
    chk("R13 disabled", {15'b0, irq}, 16'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule